// File: doc/BRIEF.md
# Memory-Increment Event Counter

This block turns a local clock or event input into a count held in system memory. It keeps no counter of its own. Software presets a memory word to the negative of the number of events it wants, then enables the device with an I/O command. Each enabled tick arms a pending flag. At the next I/O sync pulse, and only while the incoming channel daisy-chain enable is high, that flag is converted into a channel request. While the request is posted, the device raises a separate increment-memory line, so the processor adds one to the addressed word instead of moving data. When the processor grants the request, the device drives its fixed target word address onto the address lines. The device never drives data.

When the incremented word wraps to zero, the processor returns an overflow pulse. The device accepts that pulse only while it owns the current channel cycle. The pulse sets a completion flag, which raises either a level-0 priority interrupt or a program interrupt; a parameter chooses which. I/O commands set and clear the enable, clear the completion and overrun flags, and test any of these for a skip. A synchronous global clear resets every flag. A tick that arrives while a request is already posted is held in the pending flag. A further tick that arrives while the pending flag is still set is recorded as an overrun.

Top module: `mem_incr_counter`

## Requirements
- R1: After reset, status_out is 0, chan_req, incr_mem, skip_out and both interrupt outputs are low, addr_out is 0, and chain_en_out equals chain_en_in. status_out bit 0 is enable, bit 1 is the completion flag, bit 2 is overrun, and bit 3 is the pending tick.
- R2: A command acts only when cmd_valid is high and cmd_dev equals DEV_CODE. With cmd_sub 0, cmd_op bit 2 sets enable and cmd_op bit 1 clears it. When both bits are given, enable ends up set.
- R3: A tick while enable is clear has no effect on any flag.
- R4: A tick while enabled sets the pending flag. At a sync pulse with chain_en_in high, a pending flag moves into chan_req in the following cycle. While chain_en_in is low, the pending flag is kept and no request is raised.
- R5: While chan_req is high, incr_mem is high and chain_en_out is low. chan_req stays high until it is granted or cleared. Otherwise chain_en_out follows chain_en_in.
- R6: In a cycle in which grant is high and chan_req is high, addr_out equals TARGET_ADDR; in every other cycle it is 0. chan_req is low in the cycle after the grant.
- R7: A tick that arrives while chan_req is posted sets the pending flag. That flag becomes a new request at the first sync pulse after the grant.
- R8: A tick that arrives while the pending flag is already set, and is not being moved out in that cycle, sets overrun. With cmd_sub 2, cmd_op bit 1 clears overrun and cmd_op bit 0 skips if it is set.
- R9: An overflow pulse sets the completion flag only if it comes after this device's grant cycle and no later than the next sync pulse. At any other time it is ignored.
- R10: The completion flag drives irq_level0 when IRQ_LEVEL0 is 1 and irq_prog when it is 0. The other output stays low.
- R11: With cmd_sub 1, cmd_op bit 1 clears the completion flag and cmd_op bit 0 skips if it is set. With cmd_sub 0, cmd_op bit 0 skips if enable is set.
- R12: A sys_clear pulse clears enable, pending, overrun, completion and chan_req in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_clear | input | 1 | Synchronous global clear pulse |
| cmd_valid | input | 1 | I/O command strobe |
| cmd_dev | input | DEV_W | Device select code |
| cmd_sub | input | 2 | Sub-device select |
| cmd_op | input | 3 | Operation bits: 0 skip test, 1 clear, 2 set |
| skip_out | output | 1 | Skip condition satisfied |
| tick | input | 1 | Local clock/event tick, one cycle |
| sync_pulse | input | 1 | I/O sync pulse |
| chain_en_in | input | 1 | Channel daisy-chain enable from upstream |
| chain_en_out | output | 1 | Channel daisy-chain enable to downstream |
| chan_req | output | 1 | Channel request |
| incr_mem | output | 1 | Increment-memory cycle request |
| grant | input | 1 | Channel grant |
| addr_out | output | ADDR_W | Target word address during grant |
| ovf_in | input | 1 | Word-wrapped-to-zero pulse |
| irq_level0 | output | 1 | Level-0 priority interrupt request |
| irq_prog | output | 1 | Program interrupt request |
| status_out | output | 4 | {pending, overrun, done, enable} |

## Verification
The assertions assume that grant and ovf_in are pulses from a single well-behaved processor. Grant is asserted only while chan_req is high, and ovf_in comes only after a grant. They also assume that sys_clear, tick and sync_pulse are each one cycle wide. The stimulus drives every pulse for exactly one clock and issues a grant only after it has seen chan_req. Overflow pulses that arrive outside an owned cycle are injected on purpose, to show that the block ignores them rather than to violate an assumption.

// File: rtl/mic_pkg.sv
package mic_pkg;
   localparam int SUB_W = 2;
   localparam int OP_W  = 3;

   localparam logic [SUB_W-1:0] SUB_CTL  = 2'd0;
   localparam logic [SUB_W-1:0] SUB_DONE = 2'd1;
   localparam logic [SUB_W-1:0] SUB_OVR  = 2'd2;

   localparam int OP_SKIP = 0;
   localparam int OP_CLR  = 1;
   localparam int OP_SET  = 2;

   localparam int STAT_W = 4;

   typedef struct packed {
      logic en_set;
      logic en_clr;
      logic done_clr;
      logic ovr_clr;
      logic skip_en;
      logic skip_done;
      logic skip_ovr;
   } cmd_t;
endpackage

// File: rtl/mic_cmd_dec.sv
module mic_cmd_dec
   import mic_pkg::*;
#(
   parameter int DEV_W    = 6,
   parameter int DEV_CODE = 6'o32
) (
   input  logic                cmd_valid,
   input  logic [DEV_W-1:0]    cmd_dev,
   input  logic [SUB_W-1:0]    cmd_sub,
   input  logic [OP_W-1:0]     cmd_op,
   output cmd_t                cmd
);
   localparam logic [DEV_W-1:0] CODE = DEV_W'(DEV_CODE);

   if (DEV_W < 1 || DEV_W > 16) begin : g_bad_w
      $error("mic_cmd_dec: DEV_W out of range");
   end
   if (DEV_CODE < 0 || DEV_CODE >= (1 << DEV_W)) begin : g_bad_code
      $error("mic_cmd_dec: DEV_CODE does not fit DEV_W");
   end

   logic hit, ctl, dn, ov;

   always_comb begin
      hit = cmd_valid && (cmd_dev == CODE);
      ctl = hit && (cmd_sub == SUB_CTL);
      dn  = hit && (cmd_sub == SUB_DONE);
      ov  = hit && (cmd_sub == SUB_OVR);
      cmd.en_set    = ctl && cmd_op[OP_SET];
      cmd.en_clr    = ctl && cmd_op[OP_CLR];
      cmd.skip_en   = ctl && cmd_op[OP_SKIP];
      cmd.done_clr  = dn  && cmd_op[OP_CLR];
      cmd.skip_done = dn  && cmd_op[OP_SKIP];
      cmd.ovr_clr   = ov  && cmd_op[OP_CLR];
      cmd.skip_ovr  = ov  && cmd_op[OP_SKIP];
   end
endmodule

// File: rtl/mic_req_engine.sv
module mic_req_engine #(
   parameter int ADDR_W      = 15,
   parameter int TARGET_ADDR = 'h0400
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sys_clear,
   input  logic              en_set,
   input  logic              en_clr,
   input  logic              ovr_clr,
   input  logic              tick,
   input  logic              sync_pulse,
   input  logic              chain_en_in,
   input  logic              grant,
   output logic              enable,
   output logic              pending,
   output logic              overrun,
   output logic              chan_req,
   output logic              chain_en_out,
   output logic              incr_mem,
   output logic              grant_hit,
   output logic [ADDR_W-1:0] addr_out
);
   localparam logic [ADDR_W-1:0] TGT = ADDR_W'(TARGET_ADDR);

   if (ADDR_W < 1 || ADDR_W > 30) begin : g_bad_aw
      $error("mic_req_engine: ADDR_W out of range");
   end
   if (TARGET_ADDR < 0 || TARGET_ADDR >= (1 << ADDR_W)) begin : g_bad_tgt
      $error("mic_req_engine: TARGET_ADDR does not fit ADDR_W");
   end

   logic tick_ok, move;

   always_comb begin
      tick_ok   = tick && enable;
      move      = sync_pulse && chain_en_in && pending && !chan_req;
      grant_hit = grant && chan_req;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable   <= 1'b0;
         pending  <= 1'b0;
         overrun  <= 1'b0;
         chan_req <= 1'b0;
      end else if (sys_clear) begin
         enable   <= 1'b0;
         pending  <= 1'b0;
         overrun  <= 1'b0;
         chan_req <= 1'b0;
      end else begin
         if (en_set)      enable <= 1'b1;
         else if (en_clr) enable <= 1'b0;

         if (tick_ok)     pending <= 1'b1;
         else if (move)   pending <= 1'b0;

         if (tick_ok && pending && !move) overrun <= 1'b1;
         else if (ovr_clr)                overrun <= 1'b0;

         if (move)           chan_req <= 1'b1;
         else if (grant_hit) chan_req <= 1'b0;
      end
   end

   always_comb begin
      incr_mem     = chan_req;
      chain_en_out = chain_en_in && !chan_req;
      addr_out     = grant_hit ? TGT : '0;
   end

   AST_REQ_AT_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chan_req) |-> $past(sync_pulse && chain_en_in)) else $error("req rise"); // R4
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      chan_req && !grant && !sys_clear |=> chan_req) else $error("req hold"); // R5
   AST_GRANT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      chan_req && grant |=> !chan_req) else $error("grant drop"); // R6
   AST_TICK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pending) |-> $past(tick && enable)) else $error("tick gate"); // R3
endmodule

// File: rtl/mic_done_irq.sv
module mic_done_irq #(
   parameter bit IRQ_LEVEL0 = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sys_clear,
   input  logic grant_hit,
   input  logic sync_pulse,
   input  logic ovf_in,
   input  logic done_clr,
   output logic done,
   output logic irq_level0,
   output logic irq_prog
);
   logic owner;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         owner <= 1'b0;
         done  <= 1'b0;
      end else if (sys_clear) begin
         owner <= 1'b0;
         done  <= 1'b0;
      end else begin
         if (grant_hit)                owner <= 1'b1;
         else if (sync_pulse || ovf_in) owner <= 1'b0;

         if (ovf_in && owner) done <= 1'b1;
         else if (done_clr)   done <= 1'b0;
      end
   end

   if (IRQ_LEVEL0) begin : g_api
      assign irq_level0 = done;
      assign irq_prog   = 1'b0;
   end else begin : g_prog
      assign irq_level0 = 1'b0;
      assign irq_prog   = done;
   end

   AST_DONE_FROM_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(ovf_in)) else $error("done src"); // R9
   AST_ONE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq_level0 && irq_prog)) else $error("two irq"); // R10
endmodule

// File: rtl/mem_incr_counter.sv
module mem_incr_counter
   import mic_pkg::*;
#(
   parameter int DEV_W       = 6,
   parameter int DEV_CODE    = 6'o32,
   parameter int ADDR_W      = 15,
   parameter int TARGET_ADDR = 'h0400,
   parameter bit IRQ_LEVEL0  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sys_clear,
   input  logic              cmd_valid,
   input  logic [DEV_W-1:0]  cmd_dev,
   input  logic [1:0]        cmd_sub,
   input  logic [2:0]        cmd_op,
   output logic              skip_out,
   input  logic              tick,
   input  logic              sync_pulse,
   input  logic              chain_en_in,
   output logic              chain_en_out,
   output logic              chan_req,
   output logic              incr_mem,
   input  logic              grant,
   output logic [ADDR_W-1:0] addr_out,
   input  logic              ovf_in,
   output logic              irq_level0,
   output logic              irq_prog,
   output logic [3:0]        status_out
);
   cmd_t cmd;
   logic enable, pending, overrun, done, grant_hit;

   mic_cmd_dec #(.DEV_W(DEV_W), .DEV_CODE(DEV_CODE)) u_dec (
      .cmd_valid (cmd_valid),
      .cmd_dev   (cmd_dev),
      .cmd_sub   (cmd_sub),
      .cmd_op    (cmd_op),
      .cmd       (cmd)
   );

   mic_req_engine #(.ADDR_W(ADDR_W), .TARGET_ADDR(TARGET_ADDR)) u_req (
      .clk          (clk),
      .rst_n        (rst_n),
      .sys_clear    (sys_clear),
      .en_set       (cmd.en_set),
      .en_clr       (cmd.en_clr),
      .ovr_clr      (cmd.ovr_clr),
      .tick         (tick),
      .sync_pulse   (sync_pulse),
      .chain_en_in  (chain_en_in),
      .grant        (grant),
      .enable       (enable),
      .pending      (pending),
      .overrun      (overrun),
      .chan_req     (chan_req),
      .chain_en_out (chain_en_out),
      .incr_mem     (incr_mem),
      .grant_hit    (grant_hit),
      .addr_out     (addr_out)
   );

   mic_done_irq #(.IRQ_LEVEL0(IRQ_LEVEL0)) u_done (
      .clk        (clk),
      .rst_n      (rst_n),
      .sys_clear  (sys_clear),
      .grant_hit  (grant_hit),
      .sync_pulse (sync_pulse),
      .ovf_in     (ovf_in),
      .done_clr   (cmd.done_clr),
      .done       (done),
      .irq_level0 (irq_level0),
      .irq_prog   (irq_prog)
   );

   always_comb begin
      skip_out   = (cmd.skip_en && enable) || (cmd.skip_done && done) ||
                   (cmd.skip_ovr && overrun);
      status_out = {pending, overrun, done, enable};
   end

   AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      sys_clear |=> (status_out == 4'd0) && !chan_req) else $error("clear"); // R12
endmodule

// File: tb/mem_incr_counter_test.sv
module mem_incr_counter_test;
   localparam int DEV_W = 6;
   localparam int DEV   = 6'o32;
   localparam int AW    = 15;
   localparam int TGT   = 'h0400;

   logic clk = 1'b0;
   logic rst_n, sys_clear, cmd_valid, tick, sync_pulse, chain_en_in, grant, ovf_in;
   logic [DEV_W-1:0] cmd_dev;
   logic [1:0] cmd_sub;
   logic [2:0] cmd_op;
   logic skip_out, chain_en_out, chan_req, incr_mem, irq_level0, irq_prog;
   logic [AW-1:0] addr_out;
   logic [3:0] status_out;

   int checks = 0, failures = 0;
   bit done_flag = 1'b0;
   logic [AW-1:0] exp_q[$];

   always #2.5 clk = ~clk;

   mem_incr_counter #(.DEV_W(DEV_W), .DEV_CODE(DEV), .ADDR_W(AW),
                      .TARGET_ADDR(TGT), .IRQ_LEVEL0(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .sys_clear(sys_clear), .cmd_valid(cmd_valid),
      .cmd_dev(cmd_dev), .cmd_sub(cmd_sub), .cmd_op(cmd_op), .skip_out(skip_out),
      .tick(tick), .sync_pulse(sync_pulse), .chain_en_in(chain_en_in),
      .chain_en_out(chain_en_out), .chan_req(chan_req), .incr_mem(incr_mem),
      .grant(grant), .addr_out(addr_out), .ovf_in(ovf_in), .irq_level0(irq_level0),
      .irq_prog(irq_prog), .status_out(status_out));

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
      tick = 0; sync_pulse = 0; grant = 0; ovf_in = 0; sys_clear = 0; cmd_valid = 0;
      cmd_op = 0; cmd_sub = 0; cmd_dev = 0;
   endtask

   task automatic do_cmd(int dev, int sub, int op);
      cmd_valid = 1; cmd_dev = DEV_W'(dev); cmd_sub = 2'(sub); cmd_op = 3'(op);
      step();
   endtask

   task automatic skip_chk(string req, int dev, int sub, logic exp);
      cmd_valid = 1; cmd_dev = DEV_W'(dev); cmd_sub = 2'(sub); cmd_op = 3'b001;
      #1 chk(req, skip_out, exp);
      step();
   endtask

   task automatic give_grant();
      exp_q.push_back(AW'(TGT));
      grant = 1;
      step();
   endtask

   // monitor: pops expected address for each granted increment cycle
   always @(negedge clk) begin
      #1;
      if (grant && incr_mem) begin
         if (exp_q.size() == 0) chk("R6 unexpected grant", 1, 0);
         else chk("R6 addr", addr_out, exp_q.pop_front());
      end else if (rst_n) begin
         if (addr_out !== '0) chk("R6 addr idle", addr_out, 0);
      end
   end

   initial begin
      #(5.0 * 200000);
      if (!done_flag) begin
         failures++; checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      rst_n = 0; sys_clear = 0; cmd_valid = 0; cmd_dev = 0; cmd_sub = 0; cmd_op = 0;
      tick = 0; sync_pulse = 0; chain_en_in = 1; grant = 0; ovf_in = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      step();
      // R1 reset state
      chk("R1 status", status_out, 0);
      chk("R1 req", {chan_req, incr_mem, irq_level0, irq_prog}, 0);
      chk("R1 chain", chain_en_out, 1);
      // R3 ticks ignored while disabled
      tick = 1; step();
      chk("R3 disabled tick", status_out, 0);
      // R2 wrong device, then right device
      do_cmd(DEV + 1, 0, 3'b100);
      chk("R2 wrong dev", status_out[0], 0);
      do_cmd(DEV, 0, 3'b110);
      chk("R2 set+clear", status_out[0], 1);
      skip_chk("R11 skip enable", DEV, 0, 1);
      skip_chk("R11 skip other dev", DEV + 1, 0, 0);
      // R4 tick, sync with chain low keeps pending
      tick = 1; step();
      chk("R4 pending", status_out, 4'b1001);
      chain_en_in = 0; sync_pulse = 1;
      #1 chk("R5 chain follows in", chain_en_out, 0);
      step();
      chk("R4 chain low no req", {chan_req, status_out[3]}, 2'b01);
      chain_en_in = 1; sync_pulse = 1; step();
      chk("R4 req posted", {chan_req, status_out[3]}, 2'b10);
      chk("R5 incr/chain", {incr_mem, chain_en_out}, 2'b10);
      // R7 tick held, R8 overrun
      tick = 1; step();
      chk("R7 held", status_out, 4'b1001);
      tick = 1; step();
      chk("R8 overrun", status_out, 4'b1101);
      skip_chk("R8 skip overrun", DEV, 2, 1);
      // R9 overflow before grant ignored
      ovf_in = 1; step();
      chk("R9 stray ovf", status_out[1], 0);
      step();
      chk("R5 req held", chan_req, 1);
      give_grant();
      chk("R6 req dropped", {chan_req, chain_en_out}, 2'b01);
      ovf_in = 1; step();
      chk("R9 done", status_out[1], 1);
      chk("R10 irq", {irq_level0, irq_prog}, 2'b10);
      skip_chk("R11 skip done", DEV, 1, 1);
      do_cmd(DEV, 1, 3'b010);
      chk("R11 clear done", {status_out[1], irq_level0}, 0);
      do_cmd(DEV, 2, 3'b010);
      chk("R8 clear overrun", status_out, 4'b1001);
      // R7 held tick becomes request after grant
      sync_pulse = 1; step();
      chk("R7 re-request", {chan_req, status_out[3]}, 2'b10);
      give_grant();
      sync_pulse = 1; step();
      ovf_in = 1; step();
      chk("R9 ovf after sync ignored", status_out[1], 0);
      tick = 1; step();
      sync_pulse = 1; step();
      chk("R4 second req", chan_req, 1);
      sys_clear = 1; step();
      chk("R12 clear", {chan_req, status_out}, 0);
      chk("R6 queue drained", exp_q.size(), 0);
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule